// File: doc/BRIEF.md
# Two-Level Segmented Address Translator

This block turns a 24-bit virtual address into a 24-bit physical address in two steps. The top four address bits pick one of sixteen segments. A small register table holds, for each segment, the word address of that segment's page table and the number of entries the table has. The next eight bits are a page index. The index is bounded against the segment's table length before any memory traffic is made. If the index is in range, the walker fetches one 16-bit page-table entry through a memory port. The entry's frame number is joined to the untouched 12-bit byte offset.

A client offers one request at a time through a valid/ready pair. It receives a single-cycle response that carries either the physical address or a fault code. The fault code tells an out-of-range page index apart from an entry that is marked not present. The memory port raises a request and holds it until a grant comes back. The read data then arrives on a later cycle, marked by a data-valid strobe, after any number of cycles.

Top module: `seg_pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0. Every segment entry has base 0 and length 0.
- R2: When `tbl_we` is high at a clock edge, segment `tbl_idx` takes `tbl_base` and `tbl_len`. The new values apply to translations accepted afterwards. A segment with length 0 faults every page index with cause code 1.
- R3: The virtual address is split three ways. Bits 23:20 select the segment, bits 19:12 are the page index and bits 11:0 are the byte offset.
- R4: If the page index is greater than or equal to the segment's length, the response has `rsp_fault`=1, `rsp_cause`=1 and `rsp_paddr`=0. No memory request is raised for that translation.
- R5: Otherwise `mem_req` rises with `mem_addr` = segment base + page index, modulo 2^16. Both `mem_req` and `mem_addr` stay unchanged until a cycle in which `mem_gnt` is high.
- R6: The entry is taken from the first cycle with `mem_rvalid` high after the grant cycle. A `mem_rvalid` pulse seen before the grant is ignored.
- R7: An entry with bit 15 set is present. The response then has `rsp_fault`=0, `rsp_cause`=0 and `rsp_paddr` = {entry[11:0], offset}, and entry bits 14:12 have no effect.
- R8: An entry with bit 15 clear gives `rsp_fault`=1, `rsp_cause`=2 and `rsp_paddr`=0.
- R9: `req_ready` is high only while no translation is in progress. A `req_vaddr` offered while `req_ready` is low is not taken and yields no response.
- R10: Every accepted request yields exactly one response, with `rsp_valid` high for one cycle.
- R11: The length field is 9 bits wide. A length of 256 admits every page index, 255 included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Segment table write strobe |
| tbl_idx | input | 4 | Segment entry written |
| tbl_base | input | 16 | Page-table base word address |
| tbl_len | input | 9 | Page-table length in entries |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request taken |
| req_vaddr | input | 24 | Virtual address |
| mem_req | output | 1 | Page-table entry read request |
| mem_addr | output | 16 | Word address of the entry |
| mem_gnt | input | 1 | Memory accepted the read |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 16 | Page-table entry |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 index beyond length, 2 entry not present |
| rsp_paddr | output | 24 | Physical address, 0 on fault |

## Verification
The bench builds the walker with its default parameters: sixteen segments, an 8-bit page index, a 9-bit length and 16-bit entries and memory addresses. At these values the length check reaches both of its extremes. A length of 256 admits index 255, and a length equal to the index rejects it. A base near 0xFFFF shows that the entry address wraps. The bench's memory model varies the grant and data latencies and injects a stray data strobe before the grant, so the walker's wait states are exercised at zero and non-zero delay.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_SIZE = 2'd1,
    CAUSE_PTE  = 2'd2
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_WAIT,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/segtab_regs.sv
module segtab_regs #(
  parameter int IDX_W  = 4,
  parameter int BASE_W = 16,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [LEN_W-1:0]  rd_len
);
  localparam int N_SEG = 1 << IDX_W;

  logic [BASE_W-1:0] base_q [N_SEG];
  logic [LEN_W-1:0]  len_q  [N_SEG];

  for (genvar g = 0; g < N_SEG; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        len_q[g]  <= '0;
      end else if (ent_en) begin
        base_q[g] <= wr_base;
        len_q[g]  <= wr_len;
      end
    end
  end

  assign rd_base = base_q[rd_idx];
  assign rd_len  = len_q[rd_idx];

  // R2: a written entry reads back on the following cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_q[$past(wr_idx)] == $past(wr_base)) &&
              (len_q[$past(wr_idx)] == $past(wr_len)));
endmodule

// File: rtl/pte_decode.sv
module pte_decode #(
  parameter int PTE_W   = 16,
  parameter int VBIT    = 15,
  parameter int FRM_W   = 12
) (
  input  logic [PTE_W-1:0] pte,
  output logic             present,
  output logic [FRM_W-1:0] frame
);
  localparam int RSV_W = VBIT - FRM_W;

  logic [RSV_W-1:0] unused_rsv;

  assign present    = pte[VBIT];
  assign frame      = pte[FRM_W-1:0];
  assign unused_rsv = pte[VBIT-1:FRM_W];
endmodule

// File: rtl/walk_fsm.sv
module walk_fsm
  import swk_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int VPN_W  = 8,
  parameter int OFF_W  = 12,
  parameter int MA_W   = 16,
  parameter int FRM_W  = 12,
  localparam int LEN_W = VPN_W + 1,
  localparam int VA_W  = SEG_W + VPN_W + OFF_W,
  localparam int PA_W  = FRM_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic [SEG_W-1:0] tab_idx,
  input  logic [MA_W-1:0]  tab_base,
  input  logic [LEN_W-1:0] tab_len,
  output logic             mem_req,
  output logic [MA_W-1:0]  mem_addr,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic             pte_present,
  input  logic [FRM_W-1:0] pte_frame,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_paddr
);
  walk_st_e          st_q, st_d;
  logic [VA_W-1:0]   va_q;
  logic [MA_W-1:0]   addr_q, addr_d;
  logic [PA_W-1:0]   pa_q, pa_d;
  cause_e            cause_q, cause_d;
  logic              va_en, addr_en, res_en;
  logic [VPN_W-1:0]  vpn;
  logic [OFF_W-1:0]  off;
  logic              len_bad;

  assign tab_idx = va_q[VA_W-1 -: SEG_W];
  assign vpn     = va_q[OFF_W +: VPN_W];
  assign off     = va_q[OFF_W-1:0];
  assign len_bad = {1'b0, vpn} >= tab_len;
  assign addr_d  = tab_base + MA_W'(vpn);

  always_comb begin
    st_d    = st_q;
    va_en   = 1'b0;
    addr_en = 1'b0;
    res_en  = 1'b0;
    pa_d    = '0;
    cause_d = CAUSE_NONE;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        va_en = 1'b1;
        st_d  = ST_CHECK;
      end
      ST_CHECK: begin
        if (len_bad) begin
          res_en  = 1'b1;
          cause_d = CAUSE_SIZE;
          st_d    = ST_RESP;
        end else begin
          addr_en = 1'b1;
          st_d    = ST_READ;
        end
      end
      ST_READ: if (mem_gnt) st_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid) begin
        res_en = 1'b1;
        if (pte_present) begin
          pa_d = {pte_frame, off};
        end else begin
          cause_d = CAUSE_PTE;
        end
        st_d = ST_RESP;
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     va_q <= '0;
    else if (va_en) va_q <= req_vaddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q    <= '0;
      cause_q <= CAUSE_NONE;
    end else if (res_en) begin
      pa_q    <= pa_d;
      cause_q <= cause_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign mem_req   = (st_q == ST_READ);
  assign mem_addr  = addr_q;
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_fault = (cause_q != CAUSE_NONE);
  assign rsp_cause = cause_q;
  assign rsp_paddr = pa_q;

  // Checker state: a grant was seen since the last accepted request
  logic granted_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   granted_q <= 1'b0;
    else if (req_valid && req_ready) granted_q <= 1'b0;
    else if (mem_req && mem_gnt)  granted_q <= 1'b1;
  end

  a_r4_size_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == CAUSE_SIZE) |-> !granted_q);
  a_r8_invalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == CAUSE_PTE) |-> granted_q);
  a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || rsp_valid) |-> !req_ready);
  a_r10_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));
  a_r4_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

// File: rtl/seg_pt_walker.sv
module seg_pt_walker #(
  parameter int SEG_W = 4,
  parameter int VPN_W = 8,
  parameter int OFF_W = 12,
  parameter int MA_W  = 16,
  parameter int PTE_W = 16,
  parameter int VBIT  = 15,
  parameter int FRM_W = 12,
  localparam int LEN_W = VPN_W + 1,
  localparam int VA_W  = SEG_W + VPN_W + OFF_W,
  localparam int PA_W  = FRM_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [SEG_W-1:0] tbl_idx,
  input  logic [MA_W-1:0]  tbl_base,
  input  logic [LEN_W-1:0] tbl_len,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             mem_req,
  output logic [MA_W-1:0]  mem_addr,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_paddr
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [SEG_W-1:0] tab_idx;
  logic [MA_W-1:0]  tab_base;
  logic [LEN_W-1:0] tab_len;
  logic             pte_present;
  logic [FRM_W-1:0] pte_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  segtab_regs #(.IDX_W(SEG_W), .BASE_W(MA_W), .LEN_W(LEN_W)) i_tab (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (tbl_we),
    .wr_idx  (tbl_idx),
    .wr_base (tbl_base),
    .wr_len  (tbl_len),
    .rd_idx  (tab_idx),
    .rd_base (tab_base),
    .rd_len  (tab_len)
  );

  pte_decode #(.PTE_W(PTE_W), .VBIT(VBIT), .FRM_W(FRM_W)) i_dec (
    .pte     (mem_rdata),
    .present (pte_present),
    .frame   (pte_frame)
  );

  walk_fsm #(.SEG_W(SEG_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .MA_W(MA_W),
             .FRM_W(FRM_W)) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .tab_idx     (tab_idx),
    .tab_base    (tab_base),
    .tab_len     (tab_len),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_gnt     (mem_gnt),
    .mem_rvalid  (mem_rvalid),
    .pte_present (pte_present),
    .pte_frame   (pte_frame),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_cause   (rsp_cause),
    .rsp_paddr   (rsp_paddr)
  );
endmodule

// File: tb/test_seg_pt_walker.sv
module test_seg_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_idx = '0;
  logic [15:0] tbl_base = '0;
  logic [8:0]  tbl_len = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_vaddr = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic [23:0] rsp_paddr;

  int checks = 0;
  int fails = 0;
  int reads = 0;
  int gnt_lat = 0;
  int rv_lat = 0;
  bit stray = 1'b0;
  logic [15:0] last_addr = '0;
  logic [15:0] mem [256];

  always #2 clk = ~clk;

  seg_pt_walker i_seg_pt_walker (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_base(tbl_base), .tbl_len(tbl_len), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: grant after gnt_lat cycles, data rv_lat cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        for (int i = 0; i < gnt_lat; i++) begin
          mem_rvalid = stray;
          mem_rdata  = 16'h8FFF;
          @(negedge clk);
          mem_rvalid = 1'b0;
        end
        mem_gnt   = 1'b1;
        last_addr = mem_addr;
        reads++;
        @(negedge clk);
        mem_gnt = 1'b0;
        for (int i = 0; i < rv_lat; i++) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = mem[last_addr[7:0]];
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic tbl_write(logic [3:0] idx, logic [15:0] base, logic [8:0] len);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = idx; tbl_base = base; tbl_len = len;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic xlate(logic [23:0] va, logic [1:0] exp_cause, logic [23:0] exp_pa,
                       int exp_reads, logic [15:0] exp_addr, string tag);
    int r0;
    bit got;
    r0 = reads;
    got = 1'b0;
    @(negedge clk);
    chk(req_ready, {tag, " R9 idle ready"}, 32'(req_ready), 1);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200 && !got; i++) begin
      if (rsp_valid) got = 1'b1;
      else @(negedge clk);
    end
    chk(got, {tag, " R10 response seen"}, 32'(got), 1);
    chk(rsp_cause == exp_cause, {tag, " cause"}, 32'(rsp_cause), 32'(exp_cause));
    chk(rsp_fault == (exp_cause != 2'd0), {tag, " fault flag"}, 32'(rsp_fault),
        32'(exp_cause != 2'd0));
    chk(rsp_paddr == exp_pa, {tag, " paddr"}, 32'(rsp_paddr), 32'(exp_pa));
    chk(reads - r0 == exp_reads, {tag, " memory reads"}, 32'(reads - r0), 32'(exp_reads));
    if (exp_reads != 0)
      chk(last_addr == exp_addr, {tag, " R5 entry address"}, 32'(last_addr), 32'(exp_addr));
    @(negedge clk);
    chk(!rsp_valid, {tag, " R10 single cycle"}, 32'(rsp_valid), 0);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 0);
    chk(mem_req == 1'b0, "R1 no memory request after reset", 32'(mem_req), 0);
  endtask

  task automatic t_empty_segment();
    // R2: untouched segment has length 0
    xlate(24'h9_00_010, 2'd1, 24'h0, 0, 16'h0, "R2 empty segment");
  endtask

  task automatic t_basic();
    // R3 R7: seg 2, page 5, offset ABC
    xlate(24'h2_05_ABC, 2'd0, 24'h123ABC, 1, 16'h0045, "R3 R7 basic");
  endtask

  task automatic t_bounds();
    xlate(24'h2_14_000, 2'd1, 24'h0, 0, 16'h0, "R4 index equals length");
    xlate(24'h2_13_777, 2'd2, 24'h0, 1, 16'h0053, "R8 entry not present");
  endtask

  task automatic t_full_range();
    xlate(24'h5_FF_123, 2'd0, 24'hABC123, 1, 16'h01EF, "R11 length 256");
  endtask

  task automatic t_wrap();
    // R5 wrap, R7 reserved bits 14:12 ignored
    xlate(24'h6_03_FFF, 2'd0, 24'h456FFF, 1, 16'h0001, "R5 R7 wrap reserved");
  endtask

  task automatic t_latency();
    gnt_lat = 4; rv_lat = 3; stray = 1'b1;
    xlate(24'h2_06_000, 2'd0, 24'h222000, 1, 16'h0046, "R6 slow memory stray strobe");
    gnt_lat = 0; rv_lat = 0; stray = 1'b0;
  endtask

  task automatic t_busy();
    int r0;
    int nrsp;
    logic [23:0] pa;
    r0 = reads; nrsp = 0; pa = '0;
    gnt_lat = 6;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 24'h2_05_001;
    @(negedge clk);
    req_vaddr = 24'h5_FF_002;
    chk(!req_ready, "R9 not ready while busy", 32'(req_ready), 0);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (rsp_valid) begin
        nrsp++;
        pa = rsp_paddr;
      end
      @(negedge clk);
    end
    chk(nrsp == 1, "R9 one response for busy offers", 32'(nrsp), 1);
    chk(pa == 24'h123001, "R9 first address translated", 32'(pa), 32'h123001);
    chk(reads - r0 == 1, "R9 single memory read", 32'(reads - r0), 1);
    gnt_lat = 0;
  endtask

  task automatic t_rewrite();
    tbl_write(4'h2, 16'h0040, 9'd5);
    xlate(24'h2_05_ABC, 2'd1, 24'h0, 0, 16'h0, "R2 R4 rewritten length");
    xlate(24'h2_04_ABC, 2'd0, 24'h999ABC, 1, 16'h0044, "R2 rewritten in range");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[8'h45] = 16'h8123;
    mem[8'h44] = 16'h8999;
    mem[8'h46] = 16'h8222;
    mem[8'h53] = 16'h0777;
    mem[8'hEF] = 16'h8ABC;
    mem[8'h01] = 16'hF456;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_empty_segment();
    tbl_write(4'h2, 16'h0040, 9'd20);
    tbl_write(4'h5, 16'h00F0, 9'd256);
    tbl_write(4'h6, 16'hFFFE, 9'd4);
    t_basic();
    t_bounds();
    t_full_range();
    t_wrap();
    t_latency();
    t_busy();
    t_rewrite();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule